// File: doc/BRIEF.md
# SD Host Command Issue Engine

This block is the command-path front end of an SD/MMC host controller. Software writes a 32-bit argument and then a 16-bit command word over a simple register write port. Writing the command word launches a command, provided the inhibit flags allow it. The engine then hands the command index and argument to a card-side interface for one cycle. That interface stands in for the serial CMD-line shifter and CRC7 generator, which are outside this block.

When a response frame comes back, the engine can check the echoed index and the CRC verdict. It then either stores the response in four 32-bit words and pulses completion, or pulses an error. A timeout from the card side also pulses an error.

Two inhibit flags appear in a present-state word, together with the raw DAT line levels. The first guards the CMD line. The second guards the DAT lines, which stay occupied by a data transfer or by card busy signalling after a busy-type response.

Top module: `sd_cmd_issue`

## Requirements
- R1: A write with `wr_sel_i`=0 loads the argument register. A write with `wr_sel_i`=1 is a command word with the index in bits 13:8, data-present in bit 5, index-check enable in bit 4, CRC-check enable in bit 3 and response type in bits 1:0. If it is accepted, `issue_o` is high for exactly the next cycle, and during that cycle `issue_idx_o` and `issue_arg_o` carry the index and the argument held at the time of the write.
- R2: From acceptance until the next accepted command, `rsp_type_o` holds the response type and `rsp_len_o` holds the expected frame length. Type 00 means no response (length 0), 01 means 136 bits, 10 means 48 bits, and 11 means 48 bits followed by busy (length 48).
- R3: In `present_o`, bit 0 (CMD inhibit) rises in the cycle after an accepted command write and stays high until the response is captured or an error is flagged. Bit 1 is DAT inhibit. Bits 23:20 follow `dat_i[3:0]` combinationally. All other bits read 0, and all of these bits are 0 after reset.
- R4: A command with response type 00 completes without any card input. `done_o` pulses two cycles after the write, and CMD inhibit is low in that cycle.
- R5: For a 48-bit type, a valid response sampled in the waiting phase stores frame bits 39:8 in word 0 and leaves words 1 to 3 unchanged. `done_o` pulses in the following cycle.
- R6: For a 136-bit type, the CRC byte is stripped. Word k receives frame bits 32k+39 down to 32k+8, and the top 8 bits of word 3 are zero.
- R7: If CRC checking is enabled and `card_crc_ok_i` is low, or if index checking is enabled on a 48-bit type and frame bits 45:40 differ from the index, `err_o` pulses instead of `done_o`. The response words stay unchanged. Index checking never applies to the 136-bit type.
- R8: `card_timeout_i` during the waiting phase pulses `err_o` and clears CMD inhibit, and it takes priority over a simultaneous response.
- R9: DAT inhibit is set on acceptance of a command with data-present set or response type 11. A data command releases it on `xfer_done_i`. A busy command releases it at the first clock after response capture on which `dat_i[0]` is high. An error on a command that owns the DAT lines releases it at once.
- R10: A command write is ignored while CMD inhibit is set, and also while DAT inhibit is set if the new command needs the DAT lines. A command that does not need the DAT lines is accepted while DAT inhibit is set.
- R11: Response, timeout and CRC inputs have no effect outside the waiting phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects the argument, 1 selects the command word |
| wr_data_i | input | 32 | Write data; the command word uses bits 15:0 |
| dat_i | input | 4 | DAT line levels |
| xfer_done_i | input | 1 | Data path reports the end of a transfer |
| card_rsp_valid_i | input | 1 | Card side presents a response frame |
| card_rsp_i | input | 136 | Response frame, right-aligned; a 48-bit frame sits in bits 47:0 |
| card_crc_ok_i | input | 1 | CRC verdict for the presented frame |
| card_timeout_i | input | 1 | No response arrived in time |
| issue_o | output | 1 | One-cycle command launch |
| issue_idx_o | output | 6 | Index of the launched command |
| issue_arg_o | output | 32 | Argument of the launched command |
| rsp_type_o | output | 2 | Response type of the current command |
| rsp_len_o | output | 8 | Expected frame length in bits |
| present_o | output | 32 | Present-state word |
| rsp_o | output | 128 | Response words; word k is bits 32k+31:32k |
| done_o | output | 1 | Command complete pulse |
| err_o | output | 1 | Command error pulse |

## Verification
The assertions assume that the card side presents a response or a timeout only while a command is waiting for one. They also assume that a response and a completion never coincide with a new acceptance. The stimulus respects both assumptions for the cases it is meant to score. It raises the card inputs only in waiting phases, apart from one deliberate stray pulse while idle, which the checker's properties tolerate because that pulse cannot reach done, err or the response words. Busy release is driven through `dat_i[0]` only after the response has been returned, and data completion comes through `xfer_done_i` at a time the bench chooses. Every cycle is compared with a behavioural model.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rsp_kind_e;

  typedef struct packed {
    logic [5:0] idx;
    logic       data;
    logic       idx_chk;
    logic       crc_chk;
    rsp_kind_e  kind;
  } cmd_t;

  // command word field positions
  localparam int CW_IDX_LO  = 8;
  localparam int CW_DATA    = 5;
  localparam int CW_IDXCHK  = 4;
  localparam int CW_CRCCHK  = 3;
  // present-state bit positions
  localparam int PS_CMD_INH = 0;
  localparam int PS_DAT_INH = 1;
  localparam int PS_DAT_LO  = 20;
  // short-frame field positions
  localparam int SF_IDX_LO  = 40;
  localparam int SF_BODY_LO = 8;

  function automatic cmd_t decode_cmd(input logic [15:0] w);
    cmd_t c;
    c.idx     = w[CW_IDX_LO +: 6];
    c.data    = w[CW_DATA];
    c.idx_chk = w[CW_IDXCHK];
    c.crc_chk = w[CW_CRCCHK];
    c.kind    = rsp_kind_e'(w[1:0]);
    return c;
  endfunction

  function automatic logic uses_dat(input cmd_t c);
    return c.data || (c.kind == RSP_BUSY);
  endfunction
endpackage

// File: rtl/sd_cmd_regs.sv
module sd_cmd_regs
  import sd_cmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ARG_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              accept_i,
  output logic              cmd_wr_o,
  output cmd_t              new_cmd_o,
  output cmd_t              cur_cmd_o,
  output logic [ARG_W-1:0]  cur_arg_o
);
  logic [ARG_W-1:0] arg_q;
  logic [15:0]      cw;
  logic             unused_cw;

  assign cw        = wr_data_i[15:0];
  assign unused_cw = ^{cw[15:14], cw[7:6], cw[2]};
  assign cmd_wr_o  = wr_en_i && wr_sel_i;
  assign new_cmd_o = decode_cmd(cw);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arg_q     <= '0;
      cur_arg_o <= '0;
      cur_cmd_o <= '0;
    end else begin
      if (wr_en_i && !wr_sel_i) arg_q <= wr_data_i[ARG_W-1:0];
      if (accept_i) begin
        cur_cmd_o <= new_cmd_o;
        cur_arg_o <= arg_q;
      end
    end
  end
endmodule

// File: rtl/sd_cmd_fsm.sv
module sd_cmd_fsm
  import sd_cmd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_wr_i,
  input  cmd_t new_cmd_i,
  input  cmd_t cur_cmd_i,
  input  logic rsp_valid_i,
  input  logic timeout_i,
  input  logic chk_fail_i,
  input  logic dat0_i,
  input  logic xfer_done_i,
  output logic accept_o,
  output logic issue_o,
  output logic cmd_inh_o,
  output logic dat_inh_o,
  output logic cap_o,
  output logic done_o,
  output logic err_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} st_e;
  st_e  st_q, st_d;
  logic dmode_data_q, busy_arm_q;
  logic done_d, err_d, fin;

  assign accept_o  = cmd_wr_i && (st_q == ST_IDLE) && !(dat_inh_o && uses_dat(new_cmd_i));
  assign issue_o   = (st_q == ST_ISSUE);
  assign cmd_inh_o = (st_q != ST_IDLE);
  assign fin       = (st_q == ST_WAIT) && (rsp_valid_i || timeout_i);
  assign err_d     = fin && (timeout_i || chk_fail_i);
  assign cap_o     = fin && !err_d;
  assign done_d    = cap_o || ((st_q == ST_ISSUE) && (cur_cmd_i.kind == RSP_NONE));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (accept_o) st_d = ST_ISSUE;
      ST_ISSUE: st_d = (cur_cmd_i.kind == RSP_NONE) ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (fin) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      done_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
      err_o  <= err_d;
    end
  end

  // DAT line ownership: data transfer or post-response busy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_inh_o    <= 1'b0;
      dmode_data_q <= 1'b0;
      busy_arm_q   <= 1'b0;
    end else if (accept_o && uses_dat(new_cmd_i)) begin
      dat_inh_o    <= 1'b1;
      dmode_data_q <= new_cmd_i.data;
      busy_arm_q   <= 1'b0;
    end else if (err_d && uses_dat(cur_cmd_i)) begin
      dat_inh_o  <= 1'b0;
      busy_arm_q <= 1'b0;
    end else if (dat_inh_o) begin
      if (dmode_data_q) begin
        if (xfer_done_i) dat_inh_o <= 1'b0;
      end else begin
        if (busy_arm_q && dat0_i) begin
          dat_inh_o  <= 1'b0;
          busy_arm_q <= 1'b0;
        end else if (cap_o) begin
          busy_arm_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store
  import sd_cmd_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int FRAME_W = 136
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [FRAME_W-1:0]      frame_i,
  input  logic                    crc_ok_i,
  input  cmd_t                    cmd_i,
  input  logic                    cap_i,
  output logic                    chk_fail_o,
  output logic [WORD_W*WORDS-1:0] rsp_o
);
  localparam int PAY_W = FRAME_W - 16;
  localparam int PAD_W = WORD_W * WORDS - PAY_W;

  logic [WORD_W*WORDS-1:0] long_words;
  logic idx_bad, crc_bad, unused_frame;

  assign long_words   = {{PAD_W{1'b0}}, frame_i[FRAME_W-9:8]};
  assign idx_bad      = cmd_i.idx_chk && (cmd_i.kind != RSP_LONG) &&
                        (frame_i[SF_IDX_LO +: 6] != cmd_i.idx);
  assign crc_bad      = cmd_i.crc_chk && !crc_ok_i;
  assign chk_fail_o   = idx_bad || crc_bad;
  assign unused_frame = ^{frame_i[FRAME_W-1:FRAME_W-8], frame_i[7:0]};

  for (genvar j = 0; j < WORDS; j++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_o[j*WORD_W +: WORD_W] <= '0;
      end else if (cap_i) begin
        if (cmd_i.kind == RSP_LONG)
          rsp_o[j*WORD_W +: WORD_W] <= long_words[j*WORD_W +: WORD_W];
        else if (j == 0)
          rsp_o[j*WORD_W +: WORD_W] <= frame_i[SF_BODY_LO +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/sd_cmd_issue.sv
module sd_cmd_issue
  import sd_cmd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ARG_W   = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int FRAME_W = 136,
  parameter int DAT_W   = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    wr_sel_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [DAT_W-1:0]        dat_i,
  input  logic                    xfer_done_i,
  input  logic                    card_rsp_valid_i,
  input  logic [FRAME_W-1:0]      card_rsp_i,
  input  logic                    card_crc_ok_i,
  input  logic                    card_timeout_i,
  output logic                    issue_o,
  output logic [5:0]              issue_idx_o,
  output logic [ARG_W-1:0]        issue_arg_o,
  output logic [1:0]              rsp_type_o,
  output logic [7:0]              rsp_len_o,
  output logic [31:0]             present_o,
  output logic [WORD_W*WORDS-1:0] rsp_o,
  output logic                    done_o,
  output logic                    err_o
);
  localparam int SHORT_LEN = 48;

  cmd_t new_cmd, cur_cmd;
  logic cmd_wr, accept, cap, chk_fail, cmd_inh, dat_inh;

  sd_cmd_regs #(.DATA_W(DATA_W), .ARG_W(ARG_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .accept_i(accept), .cmd_wr_o(cmd_wr), .new_cmd_o(new_cmd),
    .cur_cmd_o(cur_cmd), .cur_arg_o(issue_arg_o)
  );

  sd_cmd_fsm u_fsm (
    .clk_i, .rst_ni, .cmd_wr_i(cmd_wr), .new_cmd_i(new_cmd), .cur_cmd_i(cur_cmd),
    .rsp_valid_i(card_rsp_valid_i), .timeout_i(card_timeout_i), .chk_fail_i(chk_fail),
    .dat0_i(dat_i[0]), .xfer_done_i, .accept_o(accept), .issue_o,
    .cmd_inh_o(cmd_inh), .dat_inh_o(dat_inh), .cap_o(cap), .done_o, .err_o
  );

  sd_rsp_store #(.WORD_W(WORD_W), .WORDS(WORDS), .FRAME_W(FRAME_W)) u_store (
    .clk_i, .rst_ni, .frame_i(card_rsp_i), .crc_ok_i(card_crc_ok_i),
    .cmd_i(cur_cmd), .cap_i(cap), .chk_fail_o(chk_fail), .rsp_o
  );

  assign issue_idx_o = cur_cmd.idx;
  assign rsp_type_o  = cur_cmd.kind;

  always_comb begin
    unique case (cur_cmd.kind)
      RSP_NONE: rsp_len_o = 8'd0;
      RSP_LONG: rsp_len_o = 8'(FRAME_W);
      default:  rsp_len_o = 8'(SHORT_LEN);
    endcase
  end

  always_comb begin
    present_o = '0;
    present_o[PS_CMD_INH] = cmd_inh;
    present_o[PS_DAT_INH] = dat_inh;
    present_o[PS_DAT_LO +: DAT_W] = dat_i;
  end
endmodule

// File: rtl/sd_cmd_issue_chk.sv
module sd_cmd_issue_chk (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         issue_o,
  input logic [31:0]  present_o,
  input logic [127:0] rsp_o,
  input logic         done_o,
  input logic         err_o
);
  // R1
  issue_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |=> !issue_o);
  // R1
  issue_on_inh_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_o[0]) |-> issue_o);
  // R3
  issue_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_o |-> present_o[0]);
  // R4
  done_inh_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !present_o[0]);
  // R7
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  // R7
  rsp_change_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rsp_o) |-> done_o);
endmodule

bind sd_cmd_issue sd_cmd_issue_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .issue_o(issue_o), .present_o(present_o),
  .rsp_o(rsp_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/sd_cmd_issue_bench.sv
module sd_cmd_issue_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [31:0]  wr_data_i = '0;
  logic [3:0]   dat_i = 4'hF;
  logic         xfer_done_i = 1'b0;
  logic         card_rsp_valid_i = 1'b0;
  logic [135:0] card_rsp_i = '0;
  logic         card_crc_ok_i = 1'b1;
  logic         card_timeout_i = 1'b0;
  logic         issue_o;
  logic [5:0]   issue_idx_o;
  logic [31:0]  issue_arg_o;
  logic [1:0]   rsp_type_o;
  logic [7:0]   rsp_len_o;
  logic [31:0]  present_o;
  logic [127:0] rsp_o;
  logic         done_o, err_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  sd_cmd_issue u_sd_cmd_issue (.*);

  // behavioural reference state
  int       m_st = 0;              // 0 idle, 1 issue, 2 wait
  bit [15:0]  m_cw = '0;
  bit [31:0]  m_arg = '0, m_iss_arg = '0;
  bit         m_dinh = 0, m_ddata = 0, m_barm = 0, m_done = 0, m_err = 0;
  bit [127:0] m_rsp = '0;

  task automatic model_step();
    bit [1:0] kind = m_cw[1:0];
    bit [15:0] nw = wr_data_i[15:0];
    bit need_new = nw[5] || (nw[1:0] == 2'b11);
    bit own = m_cw[5] || (kind == 2'b11);
    bit acc = wr_en_i && wr_sel_i && (m_st == 0) && !(m_dinh && need_new);
    bit nd = 0, ne = 0, cap = 0;
    int nst = m_st;
    if (m_st == 1) begin
      if (kind == 2'b00) begin nd = 1; nst = 0; end else nst = 2;
    end else if (m_st == 2) begin
      if (card_timeout_i) begin ne = 1; nst = 0; end
      else if (card_rsp_valid_i) begin
        nst = 0;
        if ((m_cw[3] && !card_crc_ok_i) ||
            (m_cw[4] && kind != 2'b01 && card_rsp_i[45:40] != m_cw[13:8])) ne = 1;
        else begin nd = 1; cap = 1; end
      end
    end
    if (cap) begin
      if (kind == 2'b01) m_rsp = {8'h00, card_rsp_i[127:8]};
      else m_rsp[31:0] = card_rsp_i[39:8];
    end
    if (acc && need_new) begin m_dinh = 1; m_ddata = nw[5]; m_barm = 0; end
    else if (ne && own) begin m_dinh = 0; m_barm = 0; end
    else if (m_dinh) begin
      if (m_ddata) begin if (xfer_done_i) m_dinh = 0; end
      else if (m_barm && dat_i[0]) begin m_dinh = 0; m_barm = 0; end
      else if (cap) m_barm = 1;
    end
    if (acc) begin m_cw = nw; m_iss_arg = m_arg; nst = 1; end
    if (wr_en_i && !wr_sel_i) m_arg = wr_data_i;
    m_st = nst; m_done = nd; m_err = ne;
  endtask

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    bit [31:0] ps = '0;
    bit [7:0] len = (m_cw[1:0] == 2'b00) ? 8'd0 : (m_cw[1:0] == 2'b01) ? 8'd136 : 8'd48;
    ps[0] = (m_st != 0); ps[1] = m_dinh; ps[23:20] = dat_i;
    chk("R1 R10 issue_o", 128'(issue_o), 128'(m_st == 1));
    if (m_st == 1) begin
      chk("R1 issue_idx_o", 128'(issue_idx_o), 128'(m_cw[13:8]));
      chk("R1 issue_arg_o", 128'(issue_arg_o), 128'(m_iss_arg));
    end
    chk("R2 rsp_type_o", 128'(rsp_type_o), 128'(m_cw[1:0]));
    chk("R2 rsp_len_o", 128'(rsp_len_o), 128'(len));
    chk("R3 R9 present_o", 128'(present_o), 128'(ps));
    chk("R4 R5 R6 R11 done_o", 128'(done_o), 128'(m_done));
    chk("R7 R8 R11 err_o", 128'(err_o), 128'(m_err));
    chk("R5 R6 R7 rsp_o", rsp_o, m_rsp);
  endtask

  task automatic tick();
    @(posedge clk_i);
    model_step();
    @(negedge clk_i);
    compare_all();
    wr_en_i = 0; card_rsp_valid_i = 0; card_timeout_i = 0; xfer_done_i = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(bit sel, bit [31:0] d);
    wr_en_i = 1; wr_sel_i = sel; wr_data_i = d;
    tick();
  endtask

  function automatic bit [31:0] cw(bit [5:0] idx, bit data, bit ic, bit cc, bit [1:0] k);
    return {16'h0, 2'b00, idx, 2'b00, data, ic, cc, 1'b0, k};
  endfunction

  function automatic bit [135:0] short_fr(bit [5:0] idx, bit [31:0] st);
    return {88'h0, 2'b00, idx, st, 7'h2B, 1'b1};
  endfunction

  task automatic respond(bit [135:0] f, bit crc_ok);
    card_rsp_i = f; card_crc_ok_i = crc_ok; card_rsp_valid_i = 1;
    tick();
  endtask

  localparam bit [119:0] LONG_PAY = 120'h0123456789ABCDEFFEDCBA98765432;

  initial begin
    @(negedge clk_i);
    compare_all();                     // R3 reset state
    @(negedge clk_i);
    rst_ni = 1;
    idle(2);
    // R1 R5: short response with both checks
    wr(0, 32'h1234_5678);
    wr(1, cw(6'd17, 0, 1, 1, 2'b10));
    idle(3);
    respond(short_fr(6'd17, 32'hCAFE_BABE), 1);
    idle(2);
    // R11: stray response while idle
    respond(short_fr(6'd17, 32'hDEAD_0000), 1);
    idle(1);
    // R6: long response, index check must not apply
    wr(0, 32'h0000_00AA);
    wr(1, cw(6'd2, 0, 1, 1, 2'b01));
    idle(1);
    respond({2'b00, 6'h3F, LONG_PAY, 7'h11, 1'b1}, 1);
    idle(2);
    // R4: no response
    wr(1, cw(6'd0, 0, 0, 0, 2'b00));
    idle(3);
    // R9: busy release after capture when dat0 high
    dat_i = 4'hE;
    wr(1, cw(6'd7, 0, 1, 1, 2'b11));
    idle(2);
    // R10: ignored while CMD inhibit set
    wr(1, cw(6'd9, 0, 0, 0, 2'b00));
    respond(short_fr(6'd7, 32'h0000_0900), 1);
    idle(3);
    // R10: busy command rejected while DAT inhibit
    wr(1, cw(6'd12, 0, 0, 0, 2'b11));
    idle(1);
    dat_i = 4'hF;
    idle(2);
    // R7: CRC failure
    wr(1, cw(6'd13, 0, 0, 1, 2'b10));
    idle(1);
    respond(short_fr(6'd13, 32'h1111_1111), 0);
    idle(1);
    // R7: index mismatch, then same with check off
    wr(1, cw(6'd14, 0, 1, 0, 2'b10));
    idle(1);
    respond(short_fr(6'd15, 32'h2222_2222), 1);
    wr(1, cw(6'd14, 0, 0, 1, 2'b10));
    idle(1);
    respond(short_fr(6'd15, 32'h3333_3333), 1);
    idle(1);
    // R8: timeout wins over response
    wr(1, cw(6'd8, 0, 0, 0, 2'b10));
    idle(1);
    card_timeout_i = 1;
    respond(short_fr(6'd8, 32'h4444_4444), 1);
    idle(1);
    // R9 R10: data command, non-DAT command accepted meanwhile
    wr(1, cw(6'd18, 1, 1, 1, 2'b10));
    idle(1);
    respond(short_fr(6'd18, 32'h5555_5555), 1);
    wr(1, cw(6'd24, 1, 0, 0, 2'b10));
    wr(1, cw(6'd13, 0, 0, 0, 2'b10));
    idle(1);
    respond(short_fr(6'd13, 32'h6666_6666), 1);
    idle(2);
    xfer_done_i = 1;
    tick();
    idle(2);
    // R7 R9: error on busy command releases DAT inhibit
    dat_i = 4'h0;
    wr(1, cw(6'd6, 0, 0, 1, 2'b11));
    idle(1);
    respond(short_fr(6'd6, 32'h7777_7777), 0);
    idle(2);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule